// File: doc/BRIEF.md
# Two-Wire Page-Write Memory Slave

This block is a serial two-wire (I2C-style) slave that accepts only write transfers and stores them in a small on-chip byte array. A transfer opens with a START and a slave byte. Two word-address bytes follow, most significant first. Any number of data bytes may come after them. The slave acknowledges every byte it accepts by pulling SDA low through an open-drain enable during the ninth clock.

Data bytes collect in a page buffer. The in-page offset steps by one per byte and wraps inside a 64-byte page, while the page number stays fixed. If a STOP closes a transfer that holds at least one accepted data byte, the block enters a busy period of a fixed number of clocks, which stands in for a nonvolatile programming cycle. At the end of that period the buffered bytes are copied into the array. During the busy period the slave ignores the bus completely. A per-block protect mask decides which parts of the array refuse data. A combinational read port exposes the array contents to the surrounding logic.

Top module: `eeprom_page_wr`

## Requirements
- R1: After reset, sda_oe_o and busy_o are low and every byte of the array reads 0.
- R2: The slave byte is acknowledged only when bits 7:4 are 1010, bits 3:1 equal DEV_SEL and bit 0 is 0. For any other slave byte the slave gives no ACK and ignores the rest of the transfer, and no busy period follows.
- R3: Both word-address bytes are acknowledged. The word address is {first byte, second byte}, and only its low ADDR_W bits are used.
- R4: A data byte aimed at an unprotected location is acknowledged. It lands at the current address once the write completes, and the offset then advances by one.
- R5: The offset is the low PAGE_W bits of the address and wraps from 63 to 0 on the same page. A transfer starting at offset 60 with 13 bytes fills offsets 60–63, then 0–7, and puts the 13th byte at offset 8.
- R6: If more than 64 data bytes are sent, each byte past the 64th overwrites the byte that was stored 64 positions earlier.
- R7: A data byte whose address falls in a block whose bit is set in prot_mask_i (block = address >> BLK_SHIFT) gets no ACK and is not stored. All later bytes of that transfer are ignored.
- R8: A STOP that ends a transfer holding at least one accepted data byte raises busy_o for exactly WRITE_CYCLES clocks. The array changes only when busy_o falls.
- R9: While busy_o is high, the slave acknowledges nothing, never drives SDA, and leaves the array and buffer untouched by bus traffic.
- R10: A START or STOP that arrives after two or more bits of a byte have been clocked aborts the transfer. An aborted transfer, or a transfer with no accepted data byte, produces no busy period and no array change.
- R11: sda_oe_o is high only while an ACK is driven. It rises after the eighth SCL falling edge of an accepted byte and drops after the ninth, so it stays low through every data-bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Open-drain enable, pulls SDA low when high |
| prot_mask_i | input | 2^(ADDR_W-BLK_SHIFT) | One write-protect bit per address block |
| busy_o | output | 1 | Internal write cycle in progress |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The bench builds the block with ADDR_W=9, PAGE_W=6, BLK_SHIFT=7 and DEV_SEL=3'b101. This gives four protect blocks and an array small enough to compare in full against a model after every scenario. It passes a word address with nonzero upper bits, so the truncation to ADDR_W is exercised. WRITE_CYCLES is set to 2000, which is long enough for a complete second transfer to be sent while the slave is busy, so the deaf period can be checked against real traffic. It is also short enough that the page-wrap and 66-byte overwrite cases fit within the run.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_SKIP} bus_st_e;
  typedef enum logic [1:0] {PH_DEV, PH_AHI, PH_ALO, PH_DATA} phase_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/epw_line_sync.sv
module epw_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[SYNC_STAGES-1];
  assign sda_s      = sda_ff[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // line conditions: SDA edge while SCL held high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_W       = 6,
  parameter int BLK_SHIFT    = 7,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   clear_i,
  input  logic                                   load_i,
  input  logic [ADDR_W-1:0]                      load_addr_i,
  input  logic                                   wr_en_i,
  input  logic [7:0]                             wr_data_i,
  input  logic                                   commit_i,
  input  logic [(1<<(ADDR_W-BLK_SHIFT))-1:0]     prot_mask_i,
  output logic                                   prot_hit_o,
  output logic                                   has_data_o,
  output logic                                   busy_o,
  output logic                                   mem_we_o,
  output logic [ADDR_W-PAGE_W-1:0]               mem_page_o,
  output logic [(1<<PAGE_W)-1:0]                 mem_mask_o,
  output logic [(1<<PAGE_W)*8-1:0]               mem_data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PAGE_IDX_W = ADDR_W - PAGE_W;
  localparam int BLK_W      = ADDR_W - BLK_SHIFT;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);

  logic [PAGE_IDX_W-1:0] page_q;
  logic [PAGE_W-1:0]     off_q;
  logic [7:0]            byte_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [CNT_W-1:0]      timer_q;
  logic                  busy_q;
  logic [BLK_W-1:0]      blk_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      off_q   <= '0;
      valid_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) byte_q[i] <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
    end else if (load_i) begin
      page_q <= load_addr_i[ADDR_W-1:PAGE_W];
      off_q  <= load_addr_i[PAGE_W-1:0];
    end else if (wr_en_i) begin
      byte_q[off_q]  <= wr_data_i;
      valid_q[off_q] <= 1'b1;
      off_q          <= off_q + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else if (busy_q) begin
      timer_q <= timer_q - 1'b1;
      if (timer_q == CNT_W'(1)) busy_q <= 1'b0;
    end else if (commit_i) begin
      busy_q  <= 1'b1;
      timer_q <= CNT_LOAD;
    end
  end

  assign blk_idx    = BLK_W'(page_q >> (BLK_SHIFT - PAGE_W));
  assign prot_hit_o = prot_mask_i[blk_idx];
  assign has_data_o = |valid_q;
  assign busy_o     = busy_q;
  assign mem_we_o   = busy_q && (timer_q == CNT_W'(1));
  assign mem_page_o = page_q;
  assign mem_mask_o = valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign mem_data_o[g*8 +: 8] = byte_q[g];
  end

  assert_no_commit_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_q);
  assert_no_fill_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !busy_q);
  assert_page_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clear_i) |=> $stable(page_q));
endmodule

// File: rtl/epw_mem_array.sv
module epw_mem_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-PAGE_W-1:0]     page_i,
  input  logic [(1<<PAGE_W)-1:0]       mask_i,
  input  logic [(1<<PAGE_W)*8-1:0]     data_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [7:0]                   rd_data_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask_i[i]) mem_q[{page_i, PAGE_W'(i)}] <= data_i[i*8 +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_page_wr.sv
module eeprom_page_wr
  import epw_pkg::*;
#(
  parameter int         ADDR_W       = 9,
  parameter int         PAGE_W       = 6,
  parameter int         BLK_SHIFT    = 7,
  parameter int         WRITE_CYCLES = 5000,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [2:0] DEV_SEL      = 3'b000
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                scl_i,
  input  logic                                sda_i,
  output logic                                sda_oe_o,
  input  logic [(1<<(ADDR_W-BLK_SHIFT))-1:0]  prot_mask_i,
  output logic                                busy_o,
  input  logic [ADDR_W-1:0]                   rd_addr_i,
  output logic [7:0]                          rd_data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PAGE_IDX_W = ADDR_W - PAGE_W;
  localparam int HI_W       = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic prot_hit, has_data, busy, mem_we;
  logic [PAGE_IDX_W-1:0]   mem_page;
  logic [PAGE_BYTES-1:0]   mem_mask;
  logic [PAGE_BYTES*8-1:0] mem_data;

  bus_st_e         state_q;
  phase_e          phase_q;
  logic [7:0]      shreg_q;
  logic [3:0]      bit_cnt_q;
  logic [HI_W-1:0] addr_hi_q;
  logic            oe_q;

  logic byte_done, dev_ok, ack_now, accept, mid_byte;
  logic clear, load, wr_en, commit;

  epw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  always_comb begin
    byte_done = !busy && (state_q == ST_RX) && scl_fall && (bit_cnt_q == 4'd8);
    dev_ok    = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:1] == DEV_SEL) && !shreg_q[0];
    unique case (phase_q)
      PH_DEV:  ack_now = dev_ok;
      PH_DATA: ack_now = !prot_hit;
      default: ack_now = 1'b1;
    endcase
    accept   = byte_done && ack_now;
    // boundary: the stop/start itself clocks in at most one bit
    mid_byte = (state_q == ST_ACK) || ((state_q == ST_RX) && (bit_cnt_q >= 4'd2));
    clear    = start_ev && !busy;
    load     = accept && (phase_q == PH_ALO);
    wr_en    = accept && (phase_q == PH_DATA);
    commit   = stop_ev && !busy && !mid_byte && has_data &&
               ((state_q == ST_RX) || (state_q == ST_SKIP));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_DEV;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      addr_hi_q <= '0;
      oe_q      <= 1'b0;
    end else if (busy) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (start_ev) begin
      state_q   <= ST_RX;
      phase_q   <= PH_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && (bit_cnt_q != 4'd8)) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (ack_now) begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              unique case (phase_q)
                PH_DEV:  phase_q <= PH_AHI;
                PH_AHI: begin
                  addr_hi_q <= shreg_q[HI_W-1:0];
                  phase_q   <= PH_ALO;
                end
                PH_ALO:  phase_q <= PH_DATA;
                default: phase_q <= PH_DATA;
              endcase
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_q      <= 1'b0;
            state_q   <= ST_RX;
            bit_cnt_q <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  epw_page_buf #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLK_SHIFT(BLK_SHIFT), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_buf (
    .clk_i, .rst_ni,
    .clear_i(clear), .load_i(load), .load_addr_i({addr_hi_q, shreg_q}),
    .wr_en_i(wr_en), .wr_data_i(shreg_q), .commit_i(commit),
    .prot_mask_i, .prot_hit_o(prot_hit), .has_data_o(has_data), .busy_o(busy),
    .mem_we_o(mem_we), .mem_page_o(mem_page), .mem_mask_o(mem_mask), .mem_data_o(mem_data)
  );

  epw_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i(mem_we), .page_i(mem_page), .mask_i(mem_mask), .data_i(mem_data),
    .rd_addr_i, .rd_data_o
  );

  assign sda_oe_o = oe_q;
  assign busy_o   = busy;

  assert_quiet_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !oe_q);
  assert_ack_on_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(scl_fall));
  assert_busy_after_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_ev));
  assert_array_only_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> !busy);
endmodule

// File: tb/eeprom_page_wr_tb_top.sv
module eeprom_page_wr_tb_top;
  localparam int         ADDR_W = 9;
  localparam int         PAGE_W = 6;
  localparam int         BLK_SH = 7;
  localparam int         WC     = 2000;
  localparam logic [2:0] DSEL   = 3'b101;
  localparam int         NBLK   = 1 << (ADDR_W - BLK_SH);
  localparam int         DEPTH  = 1 << ADDR_W;
  localparam int         Q      = 8;
  localparam logic [7:0] DEV    = {4'b1010, DSEL, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, busy;
  logic [NBLK-1:0]   prot = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic [7:0]        model [DEPTH];
  int n_chk = 0, n_err = 0;
  int busy_run = 0, last_len = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eeprom_page_wr #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLK_SHIFT(BLK_SH),
    .WRITE_CYCLES(WC), .SYNC_STAGES(2), .DEV_SEL(DSEL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(m_sda & ~sda_oe),
    .sda_oe_o(sda_oe), .prot_mask_i(prot), .busy_o(busy),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(negedge clk) begin
    if (busy) busy_run++;
    else begin
      if (busy_run != 0) last_len = busy_run;
      busy_run = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, output bit oe_mid);
    m_sda = b; wq(Q);
    scl = 1'b1; wq(Q);
    oe_mid = sda_oe; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit o, stray = 0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], o);
      stray |= o;
    end
    check("R11", "SDA driven during data bits", int'(stray), 0);
    send_bit(1'b1, o);
    ack = o;
  endtask

  task automatic do_start;
    m_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic do_stop;
    m_sda = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic txn(input logic [7:0] dev, input logic [15:0] wa, input int n,
                     input logic [7:0] seed, input bit exp_dev, input bit exp_data,
                     input string req);
    bit a;
    int base = int'(wa[ADDR_W-1:0]);
    do_start;
    send_byte(dev, a);       check(req, "slave byte ack", int'(a), int'(exp_dev));
    send_byte(wa[15:8], a);  check(exp_dev ? "R3" : req, "addr hi ack", int'(a), int'(exp_dev));
    send_byte(wa[7:0], a);   check(exp_dev ? "R3" : req, "addr lo ack", int'(a), int'(exp_dev));
    for (int i = 0; i < n; i++) begin
      send_byte(seed + 8'(i), a);
      check(req, "data ack", int'(a), int'(exp_dev && exp_data));
      if (exp_dev && exp_data)
        model[(base & ~(64 - 1)) | ((base + i) % 64)] = seed + 8'(i);
    end
    do_stop;
  endtask

  task automatic finish_write(input bit exp_busy, input string req);
    check(req, "busy after stop", int'(busy), int'(exp_busy));
    if (exp_busy) begin
      for (int k = 0; k < 4 * WC && busy; k++) wq(1);
      wq(2);
      check("R8", "busy length", last_len, WC);
    end
  endtask

  task automatic check_mem(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = ADDR_W'(a); #1;
      check(req, $sformatf("mem[%0h]", a), int'(rd_data), int'(model[a]));
    end
  endtask

  task automatic rd_check(input int a, input int exp, input string req);
    rd_addr = ADDR_W'(a); #1;
    check(req, $sformatf("mem[%0h]", a), int'(rd_data), exp);
  endtask

  task automatic t_reset;
    check("R1", "sda_oe after reset", int'(sda_oe), 0);
    check("R1", "busy after reset", int'(busy), 0);
    check_mem("R1");
  endtask

  task automatic t_basic;
    txn(DEV, 16'hFE10, 3, 8'h11, 1, 1, "R4");
    rd_check(16'h010, 0, "R8");  // not committed yet
    finish_write(1, "R8");
    check_mem("R4");
  endtask

  task automatic t_devsel;
    txn({4'b1010, 3'b000, 1'b0}, 16'h0040, 2, 8'h70, 0, 0, "R2");
    finish_write(0, "R2");
    txn({4'b1010, DSEL, 1'b1}, 16'h0040, 2, 8'h70, 0, 0, "R2");
    finish_write(0, "R2");
    txn({4'b1011, DSEL, 1'b0}, 16'h0040, 2, 8'h70, 0, 0, "R2");
    finish_write(0, "R2");
    check_mem("R2");
  endtask

  task automatic t_wrap;
    txn(DEV, 16'h00BC, 13, 8'h40, 1, 1, "R5");
    finish_write(1, "R5");
    rd_check(16'h0BF, 8'h43, "R5");
    rd_check(16'h080, 8'h44, "R5");
    rd_check(16'h088, 8'h4C, "R5");
    check_mem("R5");
  endtask

  task automatic t_overwrite;
    txn(DEV, 16'h0140, 66, 8'h80, 1, 1, "R6");
    finish_write(1, "R6");
    rd_check(16'h140, 8'hC0, "R6");
    rd_check(16'h141, 8'hC1, "R6");
    rd_check(16'h142, 8'h82, "R6");
    check_mem("R6");
  endtask

  task automatic t_protect;
    prot = 4'b1000;
    txn(DEV, 16'h0190, 3, 8'h55, 1, 0, "R7");
    finish_write(0, "R7");
    check_mem("R7");
  endtask

  task automatic t_busy;
    txn(DEV, 16'h0020, 2, 8'h21, 1, 1, "R9");
    txn(DEV, 16'h0030, 2, 8'h99, 0, 0, "R9");
    finish_write(1, "R9");
    check_mem("R9");
    prot = '0;
  endtask

  task automatic t_abort;
    bit a, o;
    do_start;
    send_byte(DEV, a); send_byte(8'h00, a); send_byte(8'h60, a);
    send_byte(8'hE1, a); check("R10", "data ack before abort", int'(a), 1);
    for (int i = 0; i < 3; i++) send_bit(1'b1, o);
    do_stop;
    finish_write(0, "R10");
    do_start;
    send_byte(DEV, a); send_byte(8'h00, a); send_byte(8'h60, a);
    do_stop;
    finish_write(0, "R10");
    do_start;
    send_byte(DEV, a); send_byte(8'h00, a); send_byte(8'h61, a); send_byte(8'hE2, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0, o);
    do_start;
    do_stop;
    finish_write(0, "R10");
    check_mem("R10");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset;
    t_basic;
    t_devsel;
    t_wrap;
    t_overwrite;
    t_protect;
    t_busy;
    t_abort;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule